// File: doc/BRIEF.md
# Buffered Page Program Sequencer

This block is a hardware master that writes a byte stream into a page-organised serial flash. It writes through the flash's internal SRAM buffer. A host pulses `start` with four values: a byte offset, a byte count, the page size in bytes, and the left shift that turns a page number into a device address. The page size need not be a power of two. The block then divides the offset into a page number and an in-page offset. It cuts the write into chunks that never cross a page boundary.

Each chunk is written in up to three phases:

1. **Preload.** Done only when the chunk covers less than a whole page. The flash copies the existing page into its buffer, so bytes outside the chunk survive.
2. **Program through the buffer.** The chunk is streamed from the valid/ready source straight into the serial frame.
3. **Compare.** Done only when the static verify input is set. The flash checks the page against its buffer.

Between phases the block polls the device status register until the ready bit is set. A compare mismatch ends the whole sequence with an error and records the failing page number. The serial link runs in mode 0, one bit every two clock cycles.

Top module: `page_prog_seq`

## Requirements
- R1: The first chunk is the smaller of (page size minus the in-page start offset) and the total length. Each later chunk is the smaller of one page and the bytes still left. After every chunk the page number goes up by one and the in-page offset becomes zero.
- R2: A chunk shorter than the page size is preceded by its own frame. That frame holds opcode 0x53 and three address bytes equal to the page number shifted left by the page shift.
- R3: The program frame holds opcode 0x82, then three address bytes sent most significant first, then exactly the chunk's data bytes taken from the source in order. The address is the page number shifted left by the page shift, plus the in-page offset.
- R4: Every command frame is followed by one or more status polls. Each poll is a separate frame: opcode 0xD7, then one byte read back. No further command frame starts until a poll returns bit 7 set.
- R5: With verify enabled, each program is followed by a frame with opcode 0x60 and the shifted page address. If the poll that ends it returns bit 6 set, `error` rises together with `done`, `err_page` holds that page number, and no further frame is issued.
- R6: `src_ready` is high only while chip select is asserted and the program frame is in its data part.
- R7: A start with length zero gives a `done` pulse with no chip-select activity.
- R8: After reset, `spi_cs_n` is high, `spi_sck` is low, and `busy`, `done`, `error` and `src_ready` are low.
- R9: The serial link is mode 0. `spi_sck` idles low while chip select is high, and `spi_mosi` does not change while `spi_sck` is high. Bytes go out most significant bit first.
- R10: `done` is a single-cycle pulse ending a sequence. A `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| start_off | input | ADDR_W | Linear byte offset of the first byte |
| length | input | LEN_W | Number of bytes to write |
| page_size | input | PS_W | Bytes per flash page |
| page_shift | input | SH_W | Left shift from page number to device address |
| verify_en | input | 1 | Add the compare phase after each program |
| src_data | input | 8 | Source data byte |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Byte accepted this cycle when valid is also high |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| error | output | 1 | The last sequence ended on a compare mismatch |
| err_page | output | ADDR_W | Page number of the failed compare |

## Verification
The checker assumes the following about the inputs:
- `page_size`, `page_shift`, `length` and the offset stay constant while `busy` is high.
- The page size is at least one.
- The page size fits below two to the page shift, so the byte offset never spills into the page bits of the address.

The stimulus keeps to these limits. Configuration is driven only between sequences, and every vector uses a matched pair such as 256 with shift 8 or 264 with shift 9. The source may hold `valid` high at any time. The properties on `src_ready` therefore rely only on the sequencer's own phase, never on the source's behaviour.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam logic [7:0] OP_LOAD = 8'h53;
  localparam logic [7:0] OP_PROG = 8'h82;
  localparam logic [7:0] OP_CMP  = 8'h60;
  localparam logic [7:0] OP_POLL = 8'hD7;
  localparam int ST_RDY = 7;
  localparam int ST_MIS = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_DIV, S_PLAN, S_HDR, S_DATA, S_GAP, S_PSEND, S_PCHK, S_NEXT
  } seq_st_t;

  typedef enum logic [1:0] {PH_LOAD, PH_PROG, PH_CMP} seq_ph_t;
endpackage

// File: rtl/pps_div.sv
module pps_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] r;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             ge;

  assign trial = {r, q[NUM_W-1]};
  assign diff  = trial - {1'b0, den};
  assign ge    = trial >= {1'b0, den};
  assign quo   = q;
  assign rem   = r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0; r <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q <= num; r <= '0; cnt <= '0; run <= 1'b1;
      end else if (run) begin
        q <= {q[NUM_W-2:0], ge};
        r <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        cnt <= cnt + 1'b1;
        if (cnt == CW'(NUM_W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pps_spi_byte.sv
module pps_spi_byte (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  logic [7:0] sh;
  logic [2:0] bc;
  logic       hi;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; bc <= '0; hi <= 1'b0; sck <= 1'b0;
      busy <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh <= tx; bc <= '0; hi <= 1'b0; sck <= 1'b0; busy <= 1'b1;
      end else if (busy) begin
        if (!hi) begin
          sck <= 1'b1;
          hi  <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          hi  <= 1'b0;
          sh  <= {sh[6:0], 1'b0};
          bc  <= bc + 1'b1;
          if (bc == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pps_geom.sv
module pps_geom #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24,
  parameter int PS_W   = 11,
  parameter int SH_W   = 4
) (
  input  logic [ADDR_W-1:0] page,
  input  logic [PS_W-1:0]   off,
  input  logic [LEN_W-1:0]  remain,
  input  logic [PS_W-1:0]   page_size,
  input  logic [SH_W-1:0]   page_shift,
  output logic [LEN_W-1:0]  chunk,
  output logic              partial,
  output logic [ADDR_W-1:0] page_addr,
  output logic [ADDR_W-1:0] prog_addr
);
  logic [PS_W-1:0]  room;
  logic [LEN_W-1:0] room_ext;

  assign room      = page_size - off;
  assign room_ext  = LEN_W'(room);
  assign chunk     = (remain < room_ext) ? remain : room_ext;
  assign partial   = chunk != LEN_W'(page_size);
  assign page_addr = page << page_shift;
  assign prog_addr = page_addr + ADDR_W'(off);
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24,
  parameter int PS_W   = 11,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_off,
  input  logic [LEN_W-1:0]  length,
  input  logic [PS_W-1:0]   page_size,
  input  logic [SH_W-1:0]   page_shift,
  input  logic              verify_en,
  input  logic [7:0]        src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] err_page
);
  seq_st_t            st;
  seq_ph_t            ph;
  logic [ADDR_W-1:0]  page;
  logic [PS_W-1:0]    off;
  logic [LEN_W-1:0]   remain;
  logic [LEN_W-1:0]   chunk_r;
  logic [LEN_W-1:0]   dcnt;
  logic [1:0]         idx;
  logic               inflight;
  logic [7:0]         stat;
  logic [PS_W-1:0]    ps_r;
  logic [SH_W-1:0]    sh_r;
  logic               ver_r;

  logic               div_start, div_done;
  logic [ADDR_W-1:0]  div_q;
  logic [PS_W-1:0]    div_r;
  logic [LEN_W-1:0]   g_chunk;
  logic               g_partial;
  logic [ADDR_W-1:0]  g_page_addr, g_prog_addr;
  logic               spi_start, spi_busy, spi_done;
  logic [7:0]         spi_tx, spi_rx;
  logic [7:0]         hdr_byte;
  logic [ADDR_W-1:0]  hdr_addr;
  logic [23:0]        addr24;

  assign busy      = st != S_IDLE;
  assign div_start = (st == S_IDLE) && start && (length != '0);

  pps_div #(.NUM_W(ADDR_W), .DEN_W(PS_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(start_off), .den(page_size),
    .done(div_done), .quo(div_q), .rem(div_r)
  );

  pps_geom #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PS_W(PS_W), .SH_W(SH_W)) u_geom (
    .page(page), .off(off), .remain(remain), .page_size(ps_r), .page_shift(sh_r),
    .chunk(g_chunk), .partial(g_partial), .page_addr(g_page_addr), .prog_addr(g_prog_addr)
  );

  // Header byte select: opcode, then address MSB first.
  assign hdr_addr = (ph == PH_PROG) ? g_prog_addr : g_page_addr;
  assign addr24   = 24'(hdr_addr);
  always_comb begin
    case (idx)
      2'd0: case (ph)
              PH_LOAD: hdr_byte = OP_LOAD;
              PH_PROG: hdr_byte = OP_PROG;
              default: hdr_byte = OP_CMP;
            endcase
      2'd1: hdr_byte = addr24[23:16];
      2'd2: hdr_byte = addr24[15:8];
      default: hdr_byte = addr24[7:0];
    endcase
  end

  assign src_ready = (st == S_DATA) && !inflight && (dcnt != '0);
  assign spi_start = (!inflight && ((st == S_HDR) || (st == S_PSEND))) ||
                     (src_valid && src_ready);
  always_comb begin
    if (st == S_DATA)       spi_tx = src_data;
    else if (st == S_PSEND) spi_tx = (idx == 2'd0) ? OP_POLL : 8'h00;
    else                    spi_tx = hdr_byte;
  end

  pps_spi_byte u_spi (
    .clk(clk), .rst(rst), .start(spi_start), .tx(spi_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .busy(spi_busy), .done(spi_done), .rx(spi_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= PH_PROG; page <= '0; off <= '0; remain <= '0;
      chunk_r <= '0; dcnt <= '0; idx <= '0; inflight <= 1'b0; stat <= '0;
      ps_r <= '0; sh_r <= '0; ver_r <= 1'b0; spi_cs_n <= 1'b1;
      done <= 1'b0; error <= 1'b0; err_page <= '0;
    end else begin
      done <= 1'b0;
      if (spi_start)     inflight <= 1'b1;
      else if (spi_done) inflight <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          error <= 1'b0;
          ps_r  <= page_size;
          sh_r  <= page_shift;
          ver_r <= verify_en;
          if (length == '0) done <= 1'b1;
          else begin
            remain <= length;
            st     <= S_DIV;
          end
        end
        S_DIV: if (div_done) begin
          page <= div_q;
          off  <= div_r;
          st   <= S_PLAN;
        end
        S_PLAN: begin
          chunk_r  <= g_chunk;
          ph       <= g_partial ? PH_LOAD : PH_PROG;
          idx      <= '0;
          spi_cs_n <= 1'b0;
          st       <= S_HDR;
        end
        S_HDR: if (spi_done) begin
          idx <= idx + 1'b1;
          if (idx == 2'd3) begin
            if (ph == PH_PROG) begin
              dcnt <= chunk_r;
              st   <= S_DATA;
            end else begin
              spi_cs_n <= 1'b1;
              st       <= S_GAP;
            end
          end
        end
        S_DATA: begin
          if (src_valid && src_ready) dcnt <= dcnt - 1'b1;
          if (dcnt == '0 && !inflight) begin
            spi_cs_n <= 1'b1;
            st       <= S_GAP;
          end
        end
        S_GAP: begin
          idx      <= '0;
          spi_cs_n <= 1'b0;
          st       <= S_PSEND;
        end
        S_PSEND: if (spi_done) begin
          idx <= idx + 1'b1;
          if (idx == 2'd1) begin
            stat     <= spi_rx;
            spi_cs_n <= 1'b1;
            st       <= S_PCHK;
          end
        end
        S_PCHK: begin
          idx <= '0;
          if (!stat[ST_RDY]) begin
            spi_cs_n <= 1'b0;
            st       <= S_PSEND;
          end else begin
            case (ph)
              PH_LOAD: begin
                ph <= PH_PROG; spi_cs_n <= 1'b0; st <= S_HDR;
              end
              PH_PROG: if (ver_r) begin
                ph <= PH_CMP; spi_cs_n <= 1'b0; st <= S_HDR;
              end else st <= S_NEXT;
              default: if (stat[ST_MIS]) begin
                error    <= 1'b1;
                err_page <= page;
                done     <= 1'b1;
                st       <= S_IDLE;
              end else st <= S_NEXT;
            endcase
          end
        end
        S_NEXT: begin
          remain <= remain - chunk_r;
          page   <= page + 1'b1;
          off    <= '0;
          if (remain == chunk_r) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else st <= S_PLAN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic src_ready,
  input logic busy,
  input logic done,
  input logic error
);
  p_ready_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> !spi_cs_n);
  p_sck_idle_r9: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> done);
  p_cs_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);
endmodule

bind page_prog_seq pps_checker u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .src_ready(src_ready), .busy(busy), .done(done),
  .error(error)
);

// File: tb/sim_page_prog_seq.sv
`timescale 1ns/1ps
module sim_page_prog_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] start_off = '0;
  logic [23:0] length = '0;
  logic [10:0] page_size = 11'd256;
  logic [3:0]  page_shift = 4'd8;
  logic        verify_en = 1'b0;
  logic [7:0]  src_data;
  logic        src_valid;
  logic        src_ready, spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic        busy, done, error;
  logic [23:0] err_page;

  always #2 clk = ~clk;

  page_prog_seq u0 (
    .clk(clk), .rst(rst), .start(start), .start_off(start_off), .length(length),
    .page_size(page_size), .page_shift(page_shift), .verify_en(verify_en),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .busy(busy), .done(done), .error(error), .err_page(err_page)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- data source ----------------
  int   src_idx = 0;
  logic src_gap = 1'b0;
  int   cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_valid && src_ready) src_idx <= src_idx + 1;
  end
  assign src_data  = 8'(src_idx) ^ 8'hA5;
  assign src_valid = !(src_gap && (cyc % 4 == 1));

  // ---------------- flash model ----------------
  int         m_bits = 0, m_nb = 0, m_data_idx = 0, m_data_bad = 0;
  logic [7:0] m_sh = '0;
  logic [7:0] m_hdr [4];
  int         busy_left = 0;
  logic       mis = 1'b0;
  logic       bad_en = 1'b0;
  logic [23:0] bad_addr = '0;
  int         polls = 0, cmd_busy_viol = 0, cs_falls = 0;
  logic [7:0] lg_op [32];
  logic [23:0] lg_addr [32];
  int         lg_len [32];
  int         lg_n = 0;
  logic [7:0] m_status;

  assign m_status = {busy_left == 0, mis, 6'b0};
  assign spi_miso = (!spi_cs_n && m_nb == 1 && m_hdr[0] == 8'hD7) ? m_status[7 - m_bits] : 1'b0;

  always @(negedge spi_cs_n) begin
    m_bits = 0; m_nb = 0; cs_falls++;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    m_sh = {m_sh[6:0], spi_mosi};
    m_bits++;
    if (m_bits == 8) begin
      m_bits = 0;
      if (m_nb < 4) m_hdr[m_nb] = m_sh;
      else begin
        if (m_sh != (8'(m_data_idx) ^ 8'hA5)) m_data_bad++;
        m_data_idx++;
      end
      m_nb++;
    end
  end

  always @(posedge spi_cs_n) if (m_nb > 0) begin
    if (m_hdr[0] == 8'hD7) begin
      polls++;
      if (busy_left > 0) busy_left--;
    end else begin
      if (busy_left > 0) cmd_busy_viol++;
      if (lg_n < 32) begin
        lg_op[lg_n]   = m_hdr[0];
        lg_addr[lg_n] = {m_hdr[1], m_hdr[2], m_hdr[3]};
        lg_len[lg_n]  = m_nb - 4;
      end
      lg_n++;
      busy_left = 2;
      mis = (m_hdr[0] == 8'h60) && bad_en && ({m_hdr[1], m_hdr[2], m_hdr[3]} == bad_addr);
    end
    m_nb = 0;
  end

  // ---------------- protocol monitors ----------------
  int rdy_viol = 0, mosi_viol = 0;
  logic p_sck = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) if (!rst) begin
    if (src_ready && !(!spi_cs_n && m_nb >= 4 && m_hdr[0] == 8'h82)) rdy_viol++;
    if (spi_sck && p_sck && spi_mosi != p_mosi) mosi_viol++;
    p_sck = spi_sck; p_mosi = spi_mosi;
  end

  // ---------------- expected sequence ----------------
  logic [7:0]  ex_op [32];
  logic [23:0] ex_addr [32];
  int          ex_len [32];
  int          ex_n, ex_bytes, ex_err, ex_errpage;

  task automatic gen_exp(input int off, input int len, input int ps, input int sh,
                         input bit ver, input bit bad, input int bad_page);
    int page, o, rem, c, pa;
    page = off / ps; o = off % ps; rem = len;
    ex_n = 0; ex_bytes = 0; ex_err = 0; ex_errpage = 0;
    while (rem > 0) begin
      c = ps - o;
      if (c > rem) c = rem;
      pa = page << sh;
      if (c != ps) begin
        ex_op[ex_n] = 8'h53; ex_addr[ex_n] = 24'(pa); ex_len[ex_n] = 0; ex_n++;
      end
      ex_op[ex_n] = 8'h82; ex_addr[ex_n] = 24'(pa + o); ex_len[ex_n] = c; ex_n++;
      ex_bytes += c;
      if (ver) begin
        ex_op[ex_n] = 8'h60; ex_addr[ex_n] = 24'(pa); ex_len[ex_n] = 0; ex_n++;
        if (bad && page == bad_page) begin
          ex_err = 1; ex_errpage = page;
          break;
        end
      end
      rem -= c; page++; o = 0;
    end
  endtask

  task automatic run_case(input int off, input int len, input int ps, input int sh,
                          input bit ver, input bit gap, input bit bad, input int bad_page,
                          input int tbl_n, input string tag);
    int hs0, bad0, pol0, w, seq_ok;
    gen_exp(off, len, ps, sh, ver, bad, bad_page);
    @(negedge clk);
    start_off = 24'(off); length = 24'(len); page_size = 11'(ps);
    page_shift = 4'(sh); verify_en = ver; src_gap = gap;
    bad_en = bad; bad_addr = 24'(bad_page << sh);
    lg_n = 0; hs0 = src_idx; bad0 = m_data_bad; pol0 = polls;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 60000) begin
      @(negedge clk); w++;
    end
    chk(done == 1'b1, {tag, " R10 done pulse"}, done, 1);
    chk(error == ex_err[0], {tag, " R5 error flag"}, error, ex_err);
    if (ex_err != 0) chk(err_page == 24'(ex_errpage), {tag, " R5 err_page"}, err_page, ex_errpage);
    if (tbl_n >= 0) chk(ex_n == tbl_n, {tag, " R1 frame count vs table"}, ex_n, tbl_n);
    chk(lg_n == ex_n, {tag, " R1 R2 frame count"}, lg_n, ex_n);
    seq_ok = 1;
    for (int i = 0; i < ex_n && i < lg_n && i < 32; i++) begin
      if (lg_op[i] != ex_op[i] || lg_addr[i] != ex_addr[i] || lg_len[i] != ex_len[i]) begin
        seq_ok = 0;
        $display("FAIL %s R2 R3 R5 frame %0d actual op=%h addr=%h len=%0d expected op=%h addr=%h len=%0d",
                 tag, i, lg_op[i], lg_addr[i], lg_len[i], ex_op[i], ex_addr[i], ex_len[i]);
      end
    end
    tests++;
    if (seq_ok == 0) fails++;
    chk(src_idx - hs0 == ex_bytes, {tag, " R3 bytes taken"}, src_idx - hs0, ex_bytes);
    chk(m_data_bad == bad0, {tag, " R3 data order"}, m_data_bad - bad0, 0);
    chk(polls - pol0 == 3 * lg_n, {tag, " R4 polls per frame"}, polls - pol0, 3 * lg_n);
  endtask

  typedef struct packed {
    logic [23:0] off;
    logic [23:0] len;
    logic [10:0] ps;
    logic [3:0]  sh;
    logic        ver;
    logic        gap;
    logic [5:0]  nfr;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{24'd0,   24'd256, 11'd256, 4'd8, 1'b0, 1'b0, 6'd1},
    '{24'd261, 24'd20,  11'd256, 4'd8, 1'b0, 1'b1, 6'd2},
    '{24'd250, 24'd300, 11'd256, 4'd8, 1'b1, 1'b0, 6'd8},
    '{24'd600, 24'd40,  11'd264, 4'd9, 1'b0, 1'b1, 6'd2},
    '{24'd264, 24'd264, 11'd264, 4'd9, 1'b1, 1'b0, 6'd2}
  };

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cf0, w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(spi_cs_n == 1'b1, "R8 cs_n", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R8 sck", spi_sck, 0);
    chk(busy == 1'b0 && done == 1'b0, "R8 busy/done", {busy, done}, 0);
    chk(error == 1'b0 && src_ready == 1'b0, "R8 error/ready", {error, src_ready}, 0);

    foreach (VECS[i])
      run_case(int'(VECS[i].off), int'(VECS[i].len), int'(VECS[i].ps), int'(VECS[i].sh),
               VECS[i].ver, VECS[i].gap, 1'b0, 0, int'(VECS[i].nfr), $sformatf("vec%0d", i));

    // R5 compare mismatch on page 1 stops the sequence
    run_case(0, 600, 256, 8, 1'b1, 1'b0, 1'b1, 1, 4, "mismatch");

    // R7 zero length
    cf0 = cs_falls;
    @(negedge clk);
    length = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R7 done on zero length", done, 1);
    repeat (20) @(negedge clk);
    chk(cs_falls == cf0, "R7 no chip select", cs_falls - cf0, 0);

    // R10 start while busy ignored
    gen_exp(5, 10, 256, 8, 1'b0, 1'b0, 0);
    @(negedge clk);
    start_off = 24'd5; length = 24'd10; page_size = 11'd256; page_shift = 4'd8;
    verify_en = 1'b0; bad_en = 1'b0; lg_n = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 still busy", busy, 1);
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk); w++;
    end
    chk(lg_n == ex_n && lg_op[1] == 8'h82 && lg_addr[1] == 24'd5 && lg_len[1] == 10,
        "R10 restart ignored", lg_n, ex_n);

    // R4 R6 R9 monitors
    chk(cmd_busy_viol == 0, "R4 command while busy", cmd_busy_viol, 0);
    chk(rdy_viol == 0, "R6 ready outside data", rdy_viol, 0);
    chk(mosi_viol == 0, "R9 mosi moved while sck high", mosi_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule